// File: doc/BRIEF.md
# Periodic Battery Load Test Scheduler

This block decides when a backup cell is put under a test load and keeps a latched, active-low battery-warning output. Once main power is reported good, it waits a recovery interval, then strobes a load-enable for a fixed number of cycles. During that strobe an external comparator reports whether the loaded cell has sagged below its trip level. A cell that sags sets the warning. A healthy cell is retested after a long interval. While the warning is set, retests come at a much shorter interval so that a swapped cell is noticed soon.

A warning clears only in two cases. The first is a passing test that follows a battery swap in which the old cell was absent for at least a minimum time. The second is a passing test that is the first test after a power-up. A short swap leaves the warning set. Loss of main power stops scheduling at once but keeps the warning. Every interval is a parameter counted in clock cycles, so a day-long schedule can be shortened to a few hundred cycles for simulation.

Top module: `batt_test_sched`

## Requirements
- R1: While rst_n is low at a clock edge, the block resets so that load_en is 0 and warn_n is 1 (no warning).
- R2: The first clock edge that samples pwr_good high after it was low or after reset starts a recovery wait. load_en goes high at the REC_DELAY-th clock edge after that edge.
- R3: Each load_en pulse that is not cut short by power loss stays high for exactly PULSE_LEN clock cycles.
- R4: A clock edge that samples pwr_good low drives load_en to 0 at that edge and abandons any pending wait or pulse. warn_n keeps its value while power is low. When power returns, the schedule restarts as in R2.
- R5: If batt_low is sampled 1 at any clock edge while load_en is high, warn_n becomes 0 at the edge that ends that pulse.
- R6: With warn_n = 1 after a pulse, the next pulse starts NORMAL_PERIOD cycles after the previous one ended.
- R7: With warn_n = 0 after a pulse, the next pulse starts WARN_PERIOD cycles after the previous one ended.
- R8: A passing test (batt_low 0 throughout the pulse) with no qualifying swap since the previous test leaves warn_n at 0.
- R9: A swap in which batt_present is sampled 0 on fewer than MIN_DETACH consecutive edges does not qualify, and the following passing test leaves warn_n at 0.
- R10: A swap in which batt_present is sampled 0 on at least MIN_DETACH consecutive edges and then 1 qualifies. The next passing test sets warn_n to 1, and the following interval is NORMAL_PERIOD.
- R11: The first completed test after a power-up clears the warning when it passes, with no swap required. The following interval is NORMAL_PERIOD.
- R12: warn_n changes only at the clock edge where a completed pulse ends; it never changes in the middle of a pulse.
- R13: Removing the battery between tests never sets the warning by itself; warn_n stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Main supply within tolerance |
| batt_low | input | 1 | Loaded-cell comparator result, 1 = below trip level; meaningful while load_en is high |
| batt_present | input | 1 | 1 = a cell is attached |
| load_en | output | 1 | 1 = apply the test load |
| warn_n | output | 1 | Latched battery warning, 0 = warning active |

## Verification
All results are registered, so each is due a whole number of edges after its cause. load_en rises REC_DELAY edges after the edge that first samples pwr_good high, stays high for PULSE_LEN edges, and rises again NORMAL_PERIOD or WARN_PERIOD edges after it falls. warn_n moves on the same edge where load_en falls and reflects batt_low as sampled on every edge of that pulse. The bench drives inputs on falling edges and samples on falling edges. Its directed checks count falling edges between events against these numbers. A cycle-level expectation model, updated on the rising edge from the same sampled inputs, is compared with both outputs on every falling edge during the directed and the random phases.

// File: rtl/bts_pkg.sv
// Shared definitions for the battery load test scheduler.
// Assumes: all intervals are positive cycle counts.
package bts_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,   // main power not good, scheduling stopped
        ST_WAIT  = 2'd1,   // counting down to the next load pulse
        ST_PULSE = 2'd2    // test load applied
    } bts_state_e;

    // Largest of four cycle counts, used to size the shared interval counter.
    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/bts_countdown.sv
// Loadable down-counter that stops at zero.
// What it does: a load takes priority over counting. zero is 1 while the
// count is 0.
// Assumes: load_val is smaller than 2**CNT_W.
module bts_countdown #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt;

    // Count held in this register; load wins, otherwise step down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/bts_detach_monitor.sv
// Measures how long the battery has been absent and flags a qualifying swap.
// What it does: repl_evt is 1 in the cycle where batt_present is sampled
// high after at least MIN_DETACH consecutive absent samples.
// Assumes: batt_present is already synchronous to clk.
module bts_detach_monitor #(
    parameter int MIN_DETACH = 56,
    parameter int ABS_W      = $clog2(MIN_DETACH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic batt_present,
    output logic repl_evt
);

    localparam logic [ABS_W-1:0] ABS_SAT = ABS_W'(MIN_DETACH);

    logic [ABS_W-1:0] absent_cnt;

    // Count absent samples and saturate at the threshold; clear once a cell is back.
    always_ff @(posedge clk) begin
        if (!rst_n)
            absent_cnt <= '0;
        else if (batt_present)
            absent_cnt <= '0;
        else if (absent_cnt != ABS_SAT)
            absent_cnt <= absent_cnt + 1'b1;
    end

    assign repl_evt = batt_present && (absent_cnt == ABS_SAT);

endmodule

// File: rtl/batt_test_sched.sv
// Periodic loaded-battery test scheduler with a latched active-low warning.
// What it does: after power is good it waits REC_DELAY cycles and then
// pulses load_en for PULSE_LEN cycles. Pulses then repeat every
// NORMAL_PERIOD idle cycles, or every WARN_PERIOD cycles while the warning
// is set. The warning is updated only at the end of a completed pulse: it
// sets on a failed test and clears on a passing test that is the first test
// after a power-up or that follows a swap with a long enough detach.
// Assumes: inputs are synchronous to clk and every interval parameter is >= 1.
module batt_test_sched
    import bts_pkg::*;
#(
    parameter int REC_DELAY     = 20,
    parameter int PULSE_LEN     = 8,
    parameter int NORMAL_PERIOD = 200,
    parameter int WARN_PERIOD   = 40,
    parameter int MIN_DETACH    = 56
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic batt_low,
    input  logic batt_present,
    output logic load_en,
    output logic warn_n
);

    localparam int MAX_T = max4(REC_DELAY, PULSE_LEN, NORMAL_PERIOD, WARN_PERIOD);
    localparam int CW    = $clog2(MAX_T + 1);

    localparam logic [CW-1:0] LD_REC  = CW'(REC_DELAY - 1);
    localparam logic [CW-1:0] LD_PULS = CW'(PULSE_LEN - 1);
    localparam logic [CW-1:0] LD_NORM = CW'(NORMAL_PERIOD - 1);
    localparam logic [CW-1:0] LD_WARN = CW'(WARN_PERIOD - 1);

    bts_state_e       state;
    logic             tmr_load;
    logic [CW-1:0]    tmr_val;
    logic             tmr_zero;
    logic             repl_evt;
    logic             fail_acc;     // batt_low seen earlier in this pulse
    logic             warn;         // latched warning, active high inside
    logic             pu_pending;   // no test has completed since power-up
    logic             repl_ok;      // a qualifying swap since the last test
    logic             pulse_done;
    logic             test_fail;
    logic             warn_next;

    bts_countdown #(.CNT_W(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    bts_detach_monitor #(.MIN_DETACH(MIN_DETACH)) u_detach (
        .clk          (clk),
        .rst_n        (rst_n),
        .batt_present (batt_present),
        .repl_evt     (repl_evt)
    );

    // Test verdict and the warning value it would leave at the end of this pulse.
    always_comb begin
        pulse_done = (state == ST_PULSE) && pwr_good && tmr_zero;
        test_fail  = fail_acc || batt_low;
        if (test_fail)
            warn_next = 1'b1;
        else if (pu_pending || repl_ok)
            warn_next = 1'b0;
        else
            warn_next = warn;
    end

    // Interval timer reload for each state change.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_OFF: begin
                if (pwr_good) begin
                    tmr_load = 1'b1;
                    tmr_val  = LD_REC;
                end
            end
            ST_WAIT: begin
                if (pwr_good && tmr_zero) begin
                    tmr_load = 1'b1;
                    tmr_val  = LD_PULS;
                end
            end
            ST_PULSE: begin
                if (pulse_done) begin
                    tmr_load = 1'b1;
                    tmr_val  = warn_next ? LD_WARN : LD_NORM;
                end
            end
            default: ;
        endcase
    end

    // Scheduler state: power loss always returns to OFF.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_OFF;
        else if (!pwr_good)
            state <= ST_OFF;
        else begin
            unique case (state)
                ST_OFF:   state <= ST_WAIT;
                ST_WAIT:  if (tmr_zero) state <= ST_PULSE;
                ST_PULSE: if (tmr_zero) state <= ST_WAIT;
                default:  state <= ST_OFF;
            endcase
        end
    end

    // Record any low comparator sample during the load pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fail_acc <= 1'b0;
        else if (state != ST_PULSE)
            fail_acc <= 1'b0;
        else
            fail_acc <= fail_acc || batt_low;
    end

    // Latched warning, updated only when a pulse completes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            warn <= 1'b0;
        else if (pulse_done)
            warn <= warn_next;
    end

    // Mark the first test after each power-up.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pu_pending <= 1'b0;
        else if (state == ST_OFF && pwr_good)
            pu_pending <= 1'b1;
        else if (pulse_done)
            pu_pending <= 1'b0;
    end

    // Qualifying swap flag: set by the detach monitor, consumed by the next test.
    always_ff @(posedge clk) begin
        if (!rst_n)
            repl_ok <= 1'b0;
        else if (repl_evt)
            repl_ok <= 1'b1;
        else if (pulse_done)
            repl_ok <= 1'b0;
    end

    assign load_en = (state == ST_PULSE);
    assign warn_n  = ~warn;

endmodule

// File: rtl/bts_checker.sv
// Property checker for batt_test_sched, attached by bind below.
// What it does: checks pulse length, power gating and when the warning may move.
// Assumes: reset is asserted for at least one edge at start-up.
module bts_checker #(
    parameter int PULSE_LEN = 8
) (
    input logic clk,
    input logic rst_n,
    input logic pwr_good,
    input logic batt_low,
    input logic load_en,
    input logic warn_n
);

    localparam int RW = $clog2(PULSE_LEN + 2);

    logic [RW-1:0] run_len;

    // Length of the current load_en run, held until the next edge after it ends.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_len <= '0;
        else if (load_en) begin
            if (run_len != {RW{1'b1}})
                run_len <= run_len + 1'b1;
        end else
            run_len <= '0;
    end

    // R3: a pulse never outlasts PULSE_LEN cycles
    assert_pulse_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> (run_len < RW'(PULSE_LEN)));

    // R3: a pulse that ends with power good lasted exactly PULSE_LEN cycles
    assert_pulse_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(load_en) && $past(pwr_good)) |-> (run_len == RW'(PULSE_LEN)));

    // R4: power loss removes the load by the next edge
    assert_pwr_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> !load_en);

    // R4: the warning holds while power is low
    assert_warn_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> $stable(warn_n));

    // R2: a pulse starts only after an edge with power good
    assert_pulse_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_en) |-> $past(pwr_good));

    // R5: a low sample on the final pulse edge leaves the warning active
    assert_fail_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(load_en) && $past(pwr_good) && $past(batt_low)) |-> !warn_n);

    // R12: the warning moves only where a pulse ends
    assert_warn_at_end_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(warn_n) |-> ($past(load_en) && !load_en));

endmodule

bind batt_test_sched bts_checker #(.PULSE_LEN(PULSE_LEN)) u_bts_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_good (pwr_good),
    .batt_low (batt_low),
    .load_en  (load_en),
    .warn_n   (warn_n)
);

// File: tb/batt_test_sched_bench.sv
// Self-checking bench: directed scenarios plus seeded random stimulus,
// compared every cycle against an expectation model written from the requirements.
module batt_test_sched_bench;

    localparam int REC  = 20;
    localparam int PLEN = 8;
    localparam int NORM = 200;
    localparam int WPER = 40;
    localparam int MDET = 56;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good = 1'b0;
    logic batt_low = 1'b0;
    logic batt_present = 1'b1;
    logic load_en;
    logic warn_n;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    batt_test_sched #(
        .REC_DELAY(REC), .PULSE_LEN(PLEN), .NORMAL_PERIOD(NORM),
        .WARN_PERIOD(WPER), .MIN_DETACH(MDET)
    ) u_batt_test_sched (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .batt_low(batt_low),
        .batt_present(batt_present), .load_en(load_en), .warn_n(warn_n)
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Expectation model, in counting-up form and built from the requirement list.
    bit m_on, m_pulse, m_warn, m_first, m_swap, m_fail;
    int m_elapsed, m_target, m_absent;

    always @(posedge clk) begin
        bit swap_now;
        if (!rst_n) begin
            m_on = 0; m_pulse = 0; m_warn = 0; m_first = 0; m_swap = 0;
            m_fail = 0; m_elapsed = 0; m_target = 0; m_absent = 0;
        end else begin
            swap_now = batt_present && (m_absent >= MDET);
            m_absent = batt_present ? 0 : m_absent + 1;
            if (!pwr_good) begin
                m_on = 0; m_pulse = 0;
            end else if (!m_on) begin
                m_on = 1; m_elapsed = 0; m_target = REC; m_first = 1;
            end else if (!m_pulse) begin
                m_elapsed++;
                if (m_elapsed == m_target) begin
                    m_pulse = 1; m_elapsed = 0; m_fail = 0;
                end
            end else begin
                m_fail = m_fail || batt_low;
                m_elapsed++;
                if (m_elapsed == PLEN) begin
                    if (m_fail) m_warn = 1;
                    else if (m_first || m_swap) m_warn = 0;
                    m_first = 0; m_swap = 0;
                    m_pulse = 0; m_elapsed = 0;
                    m_target = m_warn ? WPER : NORM;
                end
            end
            if (swap_now) m_swap = 1;
        end
    end

    // Per-cycle comparison on the falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check_eq("R2/R3/R4/R6/R7 load_en vs model", int'(load_en), int'(m_pulse));
            check_eq("R5/R8/R9/R10/R11/R13 warn_n vs model", int'(warn_n), int'(!m_warn));
        end
    end

    task automatic wait_hi(output int k);
        k = 0;
        do begin @(negedge clk); k++; end while (!load_en);
    endtask

    task automatic wait_lo(output int k);
        k = 0;
        do begin @(negedge clk); k++; end while (load_en);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(20ns * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        int k;
        int hold;
        void'($urandom(32'h5EED_0B75));

        // R1: reset state
        repeat (4) @(negedge clk);
        check_eq("R1 load_en in reset", int'(load_en), 0);
        check_eq("R1 warn_n in reset", int'(warn_n), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R2, R3, R6: power-up schedule with a healthy cell
        pwr_good = 1'b1;
        wait_hi(k); check_eq("R2 edges to first pulse", k, REC + 1);
        wait_lo(k); check_eq("R3 pulse width", k, PLEN);
        check_eq("R6 warn_n after pass", int'(warn_n), 1);
        wait_hi(k); check_eq("R6 normal interval", k, NORM);
        wait_lo(k);

        // R13: removal between tests does not raise the warning
        batt_present = 1'b0;
        repeat (30) @(negedge clk);
        check_eq("R13 warn_n with cell removed", int'(warn_n), 1);
        batt_present = 1'b1;
        wait_hi(k); wait_lo(k);
        check_eq("R13 warn_n after next test", int'(warn_n), 1);

        // R5, R12, R7: failing test
        wait_hi(k);
        batt_low = 1'b1;
        repeat (2) @(negedge clk);
        check_eq("R12 warn_n mid pulse", int'(warn_n), 1);
        wait_lo(k);
        batt_low = 1'b0;
        check_eq("R5 warn_n after failing test", int'(warn_n), 0);
        wait_hi(k); check_eq("R7 warning interval", k, WPER);

        // R8: passing test without swap keeps the warning
        wait_lo(k);
        check_eq("R8 warn_n after plain pass", int'(warn_n), 0);

        // R9: short detach does not qualify
        batt_present = 1'b0;
        repeat (MDET - 20) @(negedge clk);
        batt_present = 1'b1;
        wait_hi(k); wait_lo(k);
        check_eq("R9 warn_n after short detach", int'(warn_n), 0);

        // R10: long detach then passing test clears the warning
        batt_present = 1'b0; batt_low = 1'b1;
        repeat (MDET + 4) @(negedge clk);
        batt_present = 1'b1; batt_low = 1'b0;
        wait_hi(k); wait_lo(k);
        check_eq("R10 warn_n after qualified swap", int'(warn_n), 1);
        wait_hi(k); check_eq("R10 interval back to normal", k, NORM);

        // R4, R11: warning survives power loss; power-up pass clears it
        batt_low = 1'b1;
        wait_lo(k);
        batt_low = 1'b0;
        check_eq("R5 warn_n after second fail", int'(warn_n), 0);
        wait_hi(k);
        repeat (2) @(negedge clk);
        pwr_good = 1'b0;
        @(negedge clk);
        check_eq("R4 load_en cut by power loss", int'(load_en), 0);
        repeat (20) @(negedge clk);
        check_eq("R4 load_en while off", int'(load_en), 0);
        check_eq("R4 warn_n kept while off", int'(warn_n), 0);
        pwr_good = 1'b1;
        wait_hi(k); check_eq("R4 restart after power return", k, REC + 1);
        wait_lo(k);
        check_eq("R11 warn_n after power-up pass", int'(warn_n), 1);
        wait_hi(k); check_eq("R11 interval after power-up pass", k, NORM);

        // Random phase, checked by the model comparison.
        hold = 0;
        for (int c = 0; c < 6000; c++) begin
            @(negedge clk);
            if (pwr_good) begin
                if ($urandom_range(0, 399) == 0) pwr_good = 1'b0;
            end else if ($urandom_range(0, 29) == 0) pwr_good = 1'b1;
            if (batt_present) begin
                if ($urandom_range(0, 249) == 0) begin
                    batt_present = 1'b0;
                    hold = $urandom_range(20, 90);
                end
            end else begin
                hold--;
                if (hold <= 0) batt_present = 1'b1;
            end
            batt_low = !batt_present || ($urandom_range(0, 6) == 0);
        end

        finish_run();
    end

endmodule